// File: doc/BRIEF.md
# GPIO Port Pad Control Registers

This block keeps two small control registers for a four-pin general-purpose I/O port. One register enables a weak pull-up on each pin. The other chooses, pin by pin, between a push-pull driver and an open-drain driver. From these bits, the pin direction and output data supplied by the neighbouring port logic, and a 3-bit operating-mode code, it derives three signals for each pad: pull-up enable, output enable and drive-low.

Software reaches the registers over a byte-wide bus with a write strobe, a read strobe and a one-bit address. The control bits belong to the power-on reset domain. A power-on reset or hardware standby clears them. A manual reset or software standby leaves them intact, and writes are held off while either is active. During hardware standby every pad is also released and its pull-up switched off at once.

Top module: `gpio_pad_ctrl`

## Requirements
- R1: After a power-on reset (por_n low at a clock edge), bits 3..0 of both control registers read 0, and no pull-up is enabled.
- R2: Offset 0 (bus_addr=0) is the pull-up register and offset 1 is the open-drain register. Bit i controls pin i. Bits 7..4 ignore writes and always read as the constant 0.
- R3: In modes 1, 2, 3, 6 and 7, pu_en[i] is 1 exactly when pull-up bit i is 1 and pin_dir[i] is 0 (pin_dir 1 means output).
- R4: In modes 0, 4 and 5, every pu_en bit is 0 whatever the register contents.
- R5: In modes 1, 2, 3 and 7, a pin whose open-drain bit is 1 has oe=1 only when pin_dir is 1 and pin_dout is 0. It is released (oe=0) for data 1.
- R6: A pin whose open-drain bit is 0, or any pin in modes 0, 4, 5 and 6, is push-pull: oe[i]=pin_dir[i]. For every pin, drv_low[i]=oe[i] AND NOT pin_dout[i].
- R7: While hw_stby is 1, all oe and pu_en bits are 0 in the same cycle. At each clock edge with hw_stby high, both registers clear to 0.
- R8: Asserting mrst_n low or sw_stby high keeps both registers' contents, and bus writes made while either is active are discarded.
- R9: A write takes effect at the clock edge that samples bus_wr high, so a read in the same cycle still shows the old value. bus_rdata is 0 while bus_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, synchronous, active low |
| mrst_n | input | 1 | Manual reset, active low, holds register contents |
| hw_stby | input | 1 | Hardware standby, active high |
| sw_stby | input | 1 | Software standby, active high |
| bus_addr | input | 1 | Register offset: 0 pull-up, 1 open-drain |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when not reading |
| pin_dir | input | 4 | Per-pin direction, 1 = output |
| pin_dout | input | 4 | Per-pin output data |
| op_mode | input | 3 | Operating-mode code |
| pu_en | output | 4 | Per-pin pull-up enable |
| oe | output | 4 | Per-pin pad output enable |
| drv_low | output | 4 | Per-pin drive-low request |

## Verification
A stuck or wrongly cleared control bit shows at the pads in the same cycle, as a pull-up on an input pin that should have none or as a push-pull drive where the pin should release. It also shows on a read from the register's offset in the cycle after the faulty edge. Faults in the mode gating show only for particular mode codes, so the vectors cover every valid and invalid mode with mixed direction and data patterns. A reset-domain fault shows in the first read after a manual reset, a standby or a power-on reset.

// File: rtl/gpio_pad_pkg.sv
// Shared constants and helpers for the GPIO pad control block.
// Assumes mode codes fit in 3 bits, so a mode-enable mask is 8 bits wide.
package gpio_pad_pkg;

    localparam int MODE_W   = 3;
    localparam int MODE_CNT = 1 << MODE_W;

    typedef logic [MODE_W-1:0]   mode_t;
    typedef logic [MODE_CNT-1:0] mode_mask_t;

    // Pull-up control honoured in modes 1,2,3,6,7
    localparam mode_mask_t PU_MODES_DEF = 8'b1100_1110;
    // Open-drain selection honoured in modes 1,2,3,7
    localparam mode_mask_t OD_MODES_DEF = 8'b1000_1110;

    // Returns 1 when mode m is enabled in mask.
    function automatic logic mode_in(input mode_mask_t mask, input mode_t m);
        return mask[m];
    endfunction

endpackage

// File: rtl/gpio_mode_dec.sv
// Decodes the operating-mode code into two qualifiers: whether pull-up
// control and open-drain selection are honoured. Purely combinational.
// Assumes the masks are indexed by mode code.
module gpio_mode_dec
    import gpio_pad_pkg::*;
#(
    parameter mode_mask_t PU_MODES = PU_MODES_DEF,
    parameter mode_mask_t OD_MODES = OD_MODES_DEF
) (
    input  mode_t op_mode,
    output logic  pu_ok,
    output logic  od_ok
);

    // Look up both qualifiers for the current mode
    always_comb begin
        pu_ok = mode_in(PU_MODES, op_mode);
        od_ok = mode_in(OD_MODES, op_mode);
    end

endmodule

// File: rtl/gpio_ctl_reg.sv
// One per-pin control register in the power-on reset domain. It is cleared
// by power-on reset or hardware standby and frozen by manual reset or
// software standby. The reset is synchronous and active low.
// Assumes wr_en is already qualified by the bus address.
module gpio_ctl_reg #(
    parameter int NPIN = 4
) (
    input  logic            clk,
    input  logic            por_n,
    input  logic            hw_stby,
    input  logic            hold,
    input  logic            wr_en,
    input  logic [NPIN-1:0] wdata,
    output logic [NPIN-1:0] q
);

    // Register update: clear, hold, or load the write data
    always_ff @(posedge clk) begin
        if (!por_n || hw_stby)
            q <= '0;
        else if (wr_en && !hold)
            q <= wdata;
    end

    // R7
    hw_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
        hw_stby |=> (q == '0));

    // R8
    hold_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
        (hold && !hw_stby) |=> $stable(q));

    // R9
    write_load_chk: assert property (@(posedge clk) disable iff (!por_n)
        (wr_en && !hold && !hw_stby) |=> (q == $past(wdata)));

endmodule

// File: rtl/gpio_pad_drive.sv
// Derives pad pull-up, output-enable and drive-low for each pin from the
// control bits, direction, data and mode qualifiers. Combinational; the
// clock and reset are used only by the checks. Hardware standby forces
// every pad off.
module gpio_pad_drive #(
    parameter int NPIN = 4
) (
    input  logic            clk,
    input  logic            por_n,
    input  logic            hw_stby,
    input  logic            pu_ok,
    input  logic            od_ok,
    input  logic [NPIN-1:0] pu_bits,
    input  logic [NPIN-1:0] od_bits,
    input  logic [NPIN-1:0] dir,
    input  logic [NPIN-1:0] dout,
    output logic [NPIN-1:0] pu_en,
    output logic [NPIN-1:0] oe,
    output logic [NPIN-1:0] drv_low
);

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        logic open_drain;

        // Per-pin pad control derivation
        always_comb begin
            open_drain = od_ok && od_bits[i];
            pu_en[i]   = !hw_stby && pu_ok && pu_bits[i] && !dir[i];
            oe[i]      = !hw_stby && dir[i] && !(open_drain && dout[i]);
            drv_low[i] = oe[i] && !dout[i];
        end

        // R5
        oe_needs_dir_chk: assert property (@(posedge clk) disable iff (!por_n)
            oe[i] |-> dir[i]);

        // R4
        pu_mode_chk: assert property (@(posedge clk) disable iff (!por_n)
            !pu_ok |-> !pu_en[i]);

        // R7
        stby_off_chk: assert property (@(posedge clk) disable iff (!por_n)
            hw_stby |-> (!oe[i] && !pu_en[i]));

        // R6
        low_needs_oe_chk: assert property (@(posedge clk) disable iff (!por_n)
            drv_low[i] |-> (oe[i] && !dout[i]));
    end

endmodule

// File: rtl/gpio_pad_ctrl.sv
// Top of the GPIO pad control block: byte register bus, two control
// registers, mode decode and per-pin pad derivation.
// Assumes a one-bit address selects between the two registers and that
// the bus read data is sampled while bus_rd is high.
module gpio_pad_ctrl
    import gpio_pad_pkg::*;
#(
    parameter int         NPIN     = 4,
    parameter int         DATA_W   = 8,
    parameter mode_mask_t PU_MODES = PU_MODES_DEF,
    parameter mode_mask_t OD_MODES = OD_MODES_DEF
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              mrst_n,
    input  logic              hw_stby,
    input  logic              sw_stby,
    input  logic              bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPIN-1:0]   pin_dir,
    input  logic [NPIN-1:0]   pin_dout,
    input  logic [2:0]        op_mode,
    output logic [NPIN-1:0]   pu_en,
    output logic [NPIN-1:0]   oe,
    output logic [NPIN-1:0]   drv_low
);

    localparam int RSVD_W = DATA_W - NPIN;
    localparam int NREG   = 2;

    logic                hold;
    logic [NREG-1:0]     wr_sel;
    logic [NPIN-1:0]     reg_q [NREG];
    logic                pu_ok;
    logic                od_ok;

    // Freeze condition shared by both registers
    always_comb hold = !mrst_n || sw_stby;

    // Register bank: offset 0 pull-up, offset 1 open-drain
    for (genvar r = 0; r < NREG; r++) begin : g_reg
        // Address-qualified write strobe
        always_comb wr_sel[r] = bus_wr && (bus_addr == r[0]);

        gpio_ctl_reg #(.NPIN(NPIN)) reg_i (
            .clk     (clk),
            .por_n   (por_n),
            .hw_stby (hw_stby),
            .hold    (hold),
            .wr_en   (wr_sel[r]),
            .wdata   (bus_wdata[NPIN-1:0]),
            .q       (reg_q[r])
        );
    end

    // Read mux; reserved bits return a constant 0
    always_comb begin
        bus_rdata = '0;
        if (bus_rd)
            bus_rdata = {{RSVD_W{1'b0}}, reg_q[bus_addr]};
    end

    gpio_mode_dec #(.PU_MODES(PU_MODES), .OD_MODES(OD_MODES)) dec_i (
        .op_mode (op_mode),
        .pu_ok   (pu_ok),
        .od_ok   (od_ok)
    );

    gpio_pad_drive #(.NPIN(NPIN)) drv_i (
        .clk     (clk),
        .por_n   (por_n),
        .hw_stby (hw_stby),
        .pu_ok   (pu_ok),
        .od_ok   (od_ok),
        .pu_bits (reg_q[0]),
        .od_bits (reg_q[1]),
        .dir     (pin_dir),
        .dout    (pin_dout),
        .pu_en   (pu_en),
        .oe      (oe),
        .drv_low (drv_low)
    );

    // R9
    idle_read_chk: assert property (@(posedge clk) disable iff (!por_n)
        !bus_rd |-> (bus_rdata == '0));

    // R2
    rsvd_read_chk: assert property (@(posedge clk) disable iff (!por_n)
        bus_rdata[DATA_W-1:NPIN] == '0);

endmodule

// File: tb/gpio_pad_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_pad_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       por_n = 1'b0, mrst_n = 1'b1, hw_stby = 1'b0, sw_stby = 1'b0;
    logic       bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [3:0] pin_dir = '0, pin_dout = '0;
    logic [2:0] op_mode = 3'd1;
    logic [3:0] pu_en, oe, drv_low;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #2.5 clk = ~clk;

    gpio_pad_ctrl dut_i (
        .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .hw_stby(hw_stby),
        .sw_stby(sw_stby), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_dir(pin_dir), .pin_dout(pin_dout), .op_mode(op_mode),
        .pu_en(pu_en), .oe(oe), .drv_low(drv_low)
    );

    // Vector: mode, pu reg, od reg, dir, dout | exp pu_en, exp oe, exp drv_low
    localparam int NVEC = 10;
    localparam logic [30:0] VEC [NVEC] = '{
        {3'd1, 4'hF, 4'h0, 4'b0011, 4'b0101, 4'b1100, 4'b0011, 4'b0010}, // R3 R6
        {3'd1, 4'hA, 4'hF, 4'b1111, 4'b0110, 4'b0000, 4'b1001, 4'b1001}, // R5
        {3'd4, 4'hF, 4'hF, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000}, // R4
        {3'd5, 4'hF, 4'hF, 4'b1100, 4'b0100, 4'b0000, 4'b1100, 4'b1000}, // R4 R6
        {3'd6, 4'h5, 4'hF, 4'b0001, 4'b0000, 4'b0100, 4'b0001, 4'b0001}, // R3 R6
        {3'd7, 4'h3, 4'h5, 4'b1111, 4'b0000, 4'b0000, 4'b1111, 4'b1111}, // R5
        {3'd7, 4'h3, 4'h5, 4'b1111, 4'b1111, 4'b0000, 4'b1010, 4'b0000}, // R5
        {3'd0, 4'hF, 4'hF, 4'b0101, 4'b1010, 4'b0000, 4'b0101, 4'b0101}, // R4 R6
        {3'd2, 4'h9, 4'h3, 4'b0110, 4'b0011, 4'b1001, 4'b0100, 4'b0100}, // R3 R5
        {3'd3, 4'h6, 4'hC, 4'b1000, 4'b0000, 4'b0110, 4'b1000, 4'b1000}  // R3 R5
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #0.5;
        d = bus_rdata;
        bus_rd = 1'b0;
        #0.5;
    endtask

    // Watchdog: a hung run counts as a failure
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] r0, r1;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(1'b0, r0); rd(1'b1, r1);
        chk("R1 pu reg", {8'h0, r0 & 8'h0F}, 16'h0);
        chk("R1 od reg", {8'h0, r1 & 8'h0F}, 16'h0);
        chk("R1 pu_en", {12'h0, pu_en}, 16'h0);

        // R9 idle read returns 0
        #0.5;
        chk("R9 idle rdata", {8'h0, bus_rdata}, 16'h0);

        // R2 reserved bits ignore writes
        wr(1'b0, 8'hFF);
        rd(1'b0, r0);
        chk("R2 rsvd bits", {8'h0, r0}, 16'h000F);
        wr(1'b1, 8'hA3);
        rd(1'b1, r1);
        chk("R2 od offset", {8'h0, r1}, 16'h0003);

        // Vector table walk
        for (int v = 0; v < NVEC; v++) begin
            wr(1'b0, {4'hF, VEC[v][27:24]});
            wr(1'b1, {4'hF, VEC[v][23:20]});
            op_mode  = VEC[v][30:28];
            pin_dir  = VEC[v][19:16];
            pin_dout = VEC[v][15:12];
            rd(1'b0, r0); rd(1'b1, r1);
            chk($sformatf("R2 vec%0d readback", v),
                {r0 & 8'h0F, r1 & 8'h0F}, {4'h0, VEC[v][27:24], 4'h0, VEC[v][23:20]});
            chk($sformatf("R3 R4 R5 R6 vec%0d pads", v),
                {4'h0, pu_en, oe, drv_low}, {4'h0, VEC[v][11:0]});
        end

        // R9 same-cycle read shows old value; new after the edge
        @(negedge clk);
        bus_addr = 1'b0; bus_wdata = 8'h05; bus_wr = 1'b1; bus_rd = 1'b1;
        #0.5;
        chk("R9 before edge", {8'h0, bus_rdata & 8'h0F}, 16'h0006);
        @(negedge clk);
        bus_wr = 1'b0;
        #0.5;
        chk("R9 after edge", {8'h0, bus_rdata & 8'h0F}, 16'h0005);
        bus_rd = 1'b0;

        // R8 manual reset keeps contents and blocks writes
        @(negedge clk);
        mrst_n = 1'b0;
        wr(1'b0, 8'h00);
        @(negedge clk);
        mrst_n = 1'b1;
        rd(1'b0, r0);
        chk("R8 manual reset keep", {8'h0, r0 & 8'h0F}, 16'h0005);

        // R8 software standby keeps contents and blocks writes
        @(negedge clk);
        sw_stby = 1'b1;
        wr(1'b1, 8'h00);
        @(negedge clk);
        sw_stby = 1'b0;
        rd(1'b1, r1);
        chk("R8 sw standby keep", {8'h0, r1 & 8'h0F}, 16'h000C);

        // R7 hardware standby forces pads off at once, then clears regs
        @(negedge clk);
        op_mode = 3'd1; pin_dir = 4'b0011; pin_dout = 4'b0000;
        #0.5;
        chk("R7 pads before stby", {8'h0, pu_en, oe}, 16'h0043);
        @(negedge clk);
        hw_stby = 1'b1;
        #0.5;
        chk("R7 pads in stby", {4'h0, pu_en, oe, drv_low}, 16'h0);
        @(negedge clk);
        hw_stby = 1'b0;
        rd(1'b0, r0); rd(1'b1, r1);
        chk("R7 regs cleared", {r0 & 8'h0F, r1 & 8'h0F}, 16'h0);

        // R1 power-on reset clears again
        wr(1'b0, 8'h0F);
        wr(1'b1, 8'h0F);
        @(negedge clk);
        por_n = 1'b0;
        @(negedge clk);
        por_n = 1'b1;
        rd(1'b0, r0); rd(1'b1, r1);
        chk("R1 por clears", {r0 & 8'h0F, r1 & 8'h0F}, 16'h0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule